// File: doc/BRIEF.md
# Set/Clear Peripheral Reset Register Bank

This block holds a cluster of active-low reset lines, one for each peripheral. Software drives the lines through three 32-bit word registers on a simple register bus. Writing ones to the release word drives the matching lines high and takes those peripherals out of reset. Writing ones to the hold word drives the matching lines low and puts those peripherals into reset. Zero bits leave their lines alone, so several drivers can share the bank without a read-modify-write.

A read of the status word returns the present level of every line. A zero bit there means that the peripheral is held in reset. Bit n of each word belongs to line n. The number of lines and the line levels after the block's own reset are parameters. By default every line starts low, so every peripheral starts in reset.

Top module: `rstbank_top`

## Requirements
- R1: While `sysRstN` is low, and from then until the first accepted write, `periphRstN` equals the parameter `RST_VAL`. The default of `RST_VAL` is all zeros, meaning every peripheral is in reset.
- R2: A write (`wrEn`=1) to the hold word at offset 0x01C drives low every line n for which `wrData[n]`=1. The change appears on `periphRstN` after the next rising clock edge.
- R3: A write to the release word at offset 0x018 drives high every line n for which `wrData[n]`=1. The change appears on `periphRstN` after the next rising clock edge.
- R4: Lines whose write-data bit is zero keep their level. In a cycle with no write to offset 0x018 or 0x01C, no line changes.
- R5: A read (`rdEn`=1) of the status word at offset 0x020 returns the line levels in bits `LINES-1:0` on `rdData`, one cycle after the read is issued. The value returned is the level before any write in that same cycle, so a read issued in the cycle after a write shows that write's effect.
- R6: Status bits 31 down to `LINES` read as zero. Write-data bits at or above `LINES` have no effect on any line.
- R7: A read of offset 0x018, of offset 0x01C or of any unmapped offset returns zero. `rdData` is also zero in every cycle that does not follow a status read.
- R8: A write to any offset other than 0x018 and 0x01C leaves every line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRstN | input | 1 | Asynchronous active-low reset of the block itself |
| addr | input | ADDR_W | Byte offset of the register access |
| wrEn | input | 1 | Write strobe, one write per cycle |
| wrData | input | 32 | Write data; a one selects a line |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Read data, valid one cycle after `rdEn` |
| periphRstN | output | LINES | Active-low reset lines, one per peripheral |

## Verification
The assertions check four things on every cycle:
- a hold write leaves every selected line low;
- a release write leaves every selected line high;
- unselected lines, and all lines in cycles without a write, keep their level;
- a status read returns the previous cycle's line levels, and every other read returns zero.

Only the bench scenarios can show the reset value set by the parameter, and that data bits above the line count are inert. They also show that writes to unmapped offsets are dropped, and that a read placed right after a write sees that write. The bench does this by comparing every status read against its own model over directed and pseudo-random sequences of hold and release writes.

// File: rtl/rstbank_pkg.sv
package rstbank_pkg;
  // Strobes passed from the decoder to the line datapath.
  typedef struct packed {
    logic setStb;   // release selected lines (drive high)
    logic clrStb;   // hold selected lines (drive low)
    logic rdStat;   // status word read
  } strobe_t;
endpackage

// File: rtl/rstbank_ctrl.sv
module rstbank_ctrl #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] SET_OFS  = ADDR_W'('h18),
  parameter logic [ADDR_W-1:0] CLR_OFS  = ADDR_W'('h1C),
  parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'('h20)
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic               rdEn,
  output rstbank_pkg::strobe_t stb
);
  logic hitSet;
  logic hitClr;
  logic hitStat;

  always_comb begin
    hitSet  = (addr == SET_OFS);
    hitClr  = (addr == CLR_OFS);
    hitStat = (addr == STAT_OFS);
    // One address per cycle, so the set and clear strobes never coincide.
    stb.setStb = wrEn & hitSet;
    stb.clrStb = wrEn & hitClr;
    stb.rdStat = rdEn & hitStat;
  end
endmodule

// File: rtl/rstbank_dp.sv
module rstbank_dp #(
  parameter int LINES = 16,
  parameter logic [LINES-1:0] RST_VAL = '0,
  localparam int PAD_W = 32 - LINES
) (
  input  logic               clk,
  input  logic               sysRstN,
  input  rstbank_pkg::strobe_t stb,
  input  logic [LINES-1:0]   lineMask,
  output logic [LINES-1:0]   lineQ,
  output logic [31:0]        rdData
);
  logic [31:0] statWord;

  // Line state: release ORs the mask in, hold masks it out.
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      lineQ <= RST_VAL;
    end else if (stb.setStb) begin
      lineQ <= lineQ | lineMask;
    end else if (stb.clrStb) begin
      lineQ <= lineQ & ~lineMask;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign statWord = {{PAD_W{1'b0}}, lineQ};
    end else begin : g_full
      assign statWord = lineQ;
    end
  endgenerate

  // Registered read port: status or zero.
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      rdData <= '0;
    end else begin
      rdData <= stb.rdStat ? statWord : '0;
    end
  end

  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!sysRstN)
    stb.clrStb |=> ((lineQ & $past(lineMask)) == '0)); // R2
  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!sysRstN)
    stb.setStb |=> ((~lineQ & $past(lineMask)) == '0)); // R3
  AST_UNSELECTED_KEPT: assert property (@(posedge clk) disable iff (!sysRstN)
    (stb.setStb || stb.clrStb) |=> (((lineQ ^ $past(lineQ)) & ~$past(lineMask)) == '0)); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!sysRstN)
    !(stb.setStb || stb.clrStb) |=> $stable(lineQ)); // R4
endmodule

// File: rtl/rstbank_top.sv
module rstbank_top #(
  parameter int LINES = 16,
  parameter logic [LINES-1:0] RST_VAL = '0,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] SET_OFS  = ADDR_W'('h18),
  parameter logic [ADDR_W-1:0] CLR_OFS  = ADDR_W'('h1C),
  parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'('h20)
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  output logic [31:0]       rdData,
  output logic [LINES-1:0]  periphRstN
);
  rstbank_pkg::strobe_t stb;

  generate
    if (LINES < 32) begin : g_unusedHi
      logic unusedHi;
      assign unusedHi = ^wrData[31:LINES];
    end
  endgenerate

  rstbank_ctrl #(
    .ADDR_W(ADDR_W), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS), .STAT_OFS(STAT_OFS)
  ) u_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .stb(stb)
  );

  rstbank_dp #(.LINES(LINES), .RST_VAL(RST_VAL)) u_dp (
    .clk(clk), .sysRstN(sysRstN), .stb(stb),
    .lineMask(wrData[LINES-1:0]), .lineQ(periphRstN), .rdData(rdData)
  );

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!sysRstN)
    (rdEn && addr == STAT_OFS) |=> (rdData[LINES-1:0] == $past(periphRstN))); // R5
  AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!sysRstN)
    !(rdEn && addr == STAT_OFS) |=> (rdData == '0)); // R7
  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!sysRstN)
    (wrEn && addr != SET_OFS && addr != CLR_OFS) |=> $stable(periphRstN)); // R8
endmodule

// File: tb/rstbank_top_bench.sv
module rstbank_top_bench;
  localparam int LINES = 16;
  localparam logic [LINES-1:0] RST_VAL = 16'h8001;
  localparam logic [11:0] SET_A = 12'h018, CLR_A = 12'h01C, STAT_A = 12'h020;

  logic clk = 1'b0;
  logic sysRstN = 1'b0;
  logic [11:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [LINES-1:0] periphRstN;

  int checks = 0, fails = 0;
  logic [LINES-1:0] model;
  logic [31:0] expQ[$];
  string tagQ[$];
  logic rdSeen = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk; // 125 MHz

  rstbank_top #(.LINES(LINES), .RST_VAL(RST_VAL)) u_rstbank_top (
    .clk(clk), .sysRstN(sysRstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .periphRstN(periphRstN)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // Driver: write, update model, check lines after the edge.
  task automatic busWrite(input logic [11:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    if (a == SET_A) model = model | d[LINES-1:0];
    else if (a == CLR_A) model = model & ~d[LINES-1:0];
    @(negedge clk);
    wrEn = 1'b0;
    check(tag, 32'(periphRstN), 32'(model));
  endtask

  // Driver: read, push expected item for the monitor.
  task automatic busRead(input logic [11:0] a, input string tag);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    expQ.push_back(a == STAT_A ? {16'h0, model} : 32'h0);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // Write immediately followed by a status read in the next cycle.
  task automatic writeThenRead(input logic [11:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    if (a == SET_A) model = model | d[LINES-1:0];
    else if (a == CLR_A) model = model & ~d[LINES-1:0];
    @(negedge clk);
    wrEn = 1'b0; addr = STAT_A; rdEn = 1'b1;
    expQ.push_back({16'h0, model});
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // Monitor
  always @(posedge clk) rdSeen = rdEn;
  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      check(tagQ.pop_front(), rdData, expQ.pop_front());
    end else if (sysRstN) begin
      check("R7 idle zero", rdData, 32'h0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    model = RST_VAL;
    repeat (2) @(negedge clk);
    check("R1 during reset", 32'(periphRstN), 32'(RST_VAL));
    sysRstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", 32'(periphRstN), 32'(RST_VAL));
    busRead(STAT_A, "R1 R5 status after reset");

    busWrite(SET_A, 32'h0000_0008, "R3 single release");
    busRead(STAT_A, "R5 status after single release");
    busWrite(SET_A, 32'h0000_0F00, "R3 multi release");
    busRead(STAT_A, "R5 status after multi release");
    busWrite(CLR_A, 32'h0000_8000, "R2 single hold");
    busRead(STAT_A, "R5 status after single hold");
    busWrite(CLR_A, 32'h0000_0301, "R2 R4 multi hold");
    busRead(STAT_A, "R4 untouched lines");
    busWrite(SET_A, 32'h0, "R4 zero-data release");
    busWrite(CLR_A, 32'h0, "R4 zero-data hold");
    busWrite(SET_A, 32'hFFFF_0000, "R6 upper data bits inert");
    busRead(STAT_A, "R6 upper status bits zero");
    busWrite(12'h024, 32'hFFFF_FFFF, "R8 foreign write");
    busWrite(12'h000, 32'hFFFF_FFFF, "R8 foreign write low");
    busRead(STAT_A, "R8 status after foreign writes");
    busRead(SET_A, "R7 release word reads zero");
    busRead(CLR_A, "R7 hold word reads zero");
    busRead(12'h024, "R7 unmapped reads zero");
    writeThenRead(SET_A, 32'h0000_FFFF, "R5 read right after release");
    writeThenRead(CLR_A, 32'h0000_A5A5, "R5 read right after hold");

    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      busWrite(lfsr[0] ? SET_A : CLR_A, {lfsr, lfsr ^ 16'h5A3C}, "R2 R3 R4 random write");
      busRead(STAT_A, "R5 random status");
    end

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule